// File: doc/BRIEF.md
# Sampling Converter Conversion Sequencer

This block is the clock-synchronous control side of a successive-approximation converter with a parallel result port. It watches four asynchronous control pins: an active-low convert request, an active-low select, an active-low read strobe and a half-word select. It decides when a conversion runs and reports that on `busy`. When a conversion ends normally it captures the word produced by the analog core into an output latch. It presents that latch on a parallel bus, modelled as a data vector plus an enable.

A conversion that is still running can be cut short by a second convert request or by a new select edge. Such an abort acts like a local reset: the conversion stops, the output latch is cleared and a fresh acquisition begins. The asynchronous reset pin has the same effect at any time. The bus can deliver the whole word, or, for a narrow host, the low half of the word moved onto the upper lanes.

Top module: `sar_seq_ctrl`

## Requirements
- R1: A falling edge on `cnv_n` while `sel_n` is low starts a conversion when none is running, and `busy` then stays high for exactly `CONV_CYCLES` clock cycles.
- R2: A falling edge on `cnv_n` while `sel_n` is high does not start a conversion, and `busy` stays low.
- R3: When a conversion completes without abort, the value on `core_word` in its last cycle becomes the latched result that is read back on the bus.
- R4: A falling edge on `cnv_n` with `sel_n` low, arriving at least `ABORT_MIN` cycles into a conversion, ends it early: `busy` falls before `CONV_CYCLES` cycles have elapsed and the latched result becomes 0000 hex.
- R5: A falling edge on `sel_n` arriving at least `ABORT_MIN` cycles into a conversion ends it early in the same way as R4, with the result cleared to 0000 hex.
- R6: Convert or select edges that arrive fewer than `ABORT_MIN` cycles after a conversion starts have no effect: the conversion runs its full length and captures `core_word`.
- R7: When an aborting edge is seen in the same cycle as the final conversion cycle, the abort takes priority: `busy` falls on time, but the result is cleared to 0000 hex and `core_word` is not captured.
- R8: Driving `arst_n` low forces `busy` low at once, even mid-conversion, and clears the latched result to 0000 hex.
- R9: `bus_oe` is high only while `sel_n` and `rd_n` are both low; whenever `bus_oe` is low, `bus_data` is 0000 hex.
- R10: With `hi_byte` low the bus carries the full 16-bit result with bit 15 on bit 15; with `hi_byte` high bits 15:8 carry result bits 7:0 and bits 7:0 are all ones.
- R11: While a conversion runs, the bus keeps showing the previous result.
- R12: The result is passed unchanged as a two's complement code; the extreme codes 7FFF, 8000 and FFFF hex read back exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnv_n | input | 1 | Active-low convert request; its falling edge starts or aborts |
| sel_n | input | 1 | Active-low select; gates starts and enables the bus |
| rd_n | input | 1 | Active-low read strobe |
| hi_byte | input | 1 | High: low result half is moved onto the upper lanes |
| core_word | input | 16 | Result word from the analog core stub |
| busy | output | 1 | High while a conversion runs |
| bus_data | output | 16 | Parallel result bus value |
| bus_oe | output | 1 | Bus drive enable; low models high impedance |

## Verification
The abort path and the normal completion path can both act on the same clock edge. They disagree on the value left in the result latch, so that edge decides which path wins. The bench forces the clash by placing a second `cnv_n` falling edge exactly `CONV_CYCLES` cycles after the first. After synchronization, the edge then reaches the sequencer in the final conversion cycle. The run passes only if `busy` still lasts the full length and the bus reads 0000 hex instead of the core word. Separate runs with early and mid-conversion edges show that each path works on its own.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
    typedef enum logic [1:0] {
        ST_ACQ  = 2'd0,
        ST_CONV = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_e;

    localparam int IDX_CNV  = 0;
    localparam int IDX_SEL  = 1;
    localparam int IDX_RD   = 2;
    localparam int IDX_BYTE = 3;
    localparam int N_CTRL   = 4;
endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end

    assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/seq_ctrl_sync.sv
module seq_ctrl_sync #(
    parameter int              WIDTH  = 4,
    parameter int              STAGES = 2,
    parameter logic [WIDTH-1:0] IDLE  = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o
);
    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= IDLE;
        end else begin
            stg_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign level_o = stg_q[STAGES-1];
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import sar_seq_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int CONV_CYCLES = 12,
    parameter int ABORT_MIN   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnv_lvl,
    input  logic              sel_lvl,
    input  logic [DATA_W-1:0] core_word,
    output logic              busy_o,
    output logic [DATA_W-1:0] result_o
);
    localparam int CNT_W = $clog2(CONV_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(CONV_CYCLES - 1);
    localparam logic [CNT_W-1:0] ABORT_CNT = CNT_W'(ABORT_MIN);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] res;
        logic              cnv_prev;
        logic              sel_prev;
    } fsm_regs_t;

    fsm_regs_t cur_q, nxt_d;
    logic cnv_fall, sel_fall, sel_low, late, abort_hit, done_hit;

    always_comb begin
        nxt_d     = cur_q;
        cnv_fall  = cur_q.cnv_prev & ~cnv_lvl;
        sel_fall  = cur_q.sel_prev & ~sel_lvl;
        sel_low   = ~sel_lvl;
        late      = (cur_q.cnt >= ABORT_CNT);
        abort_hit = 1'b0;
        done_hit  = 1'b0;
        nxt_d.cnv_prev = cnv_lvl;
        nxt_d.sel_prev = sel_lvl;
        case (cur_q.st)
            ST_ACQ: begin
                if (cnv_fall && sel_low) begin
                    nxt_d.st  = ST_CONV;
                    nxt_d.cnt = '0;
                end
            end
            ST_WAIT: begin
                if (sel_fall) nxt_d.st = ST_ACQ;
            end
            ST_CONV: begin
                nxt_d.cnt = cur_q.cnt + 1'b1;
                abort_hit = late && ((cnv_fall && sel_low) || sel_fall);
                done_hit  = (cur_q.cnt == LAST_CNT);
                if (abort_hit) begin
                    nxt_d.st  = ST_ACQ;
                    nxt_d.res = '0;
                end else if (done_hit) begin
                    nxt_d.st  = sel_low ? ST_ACQ : ST_WAIT;
                    nxt_d.res = core_word;
                end
            end
            default: nxt_d.st = ST_ACQ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st       <= ST_ACQ;
            cur_q.cnt      <= '0;
            cur_q.res      <= '0;
            cur_q.cnv_prev <= 1'b1;
            cur_q.sel_prev <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy_o   = (cur_q.st == ST_CONV);
    assign result_o = cur_q.res;

    AST_END_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_CONV && cur_q.cnt == LAST_CNT) |=> (cur_q.st != ST_CONV)); // R1
    AST_START_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(sel_low)); // R2
    AST_EARLY_EDGE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_CONV && cur_q.cnt < ABORT_CNT) |=> (cur_q.st == ST_CONV)); // R6
    AST_RESULT_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> $stable(result_o)); // R11
endmodule

// File: rtl/seq_bus.sv
module seq_bus #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_low,
    input  logic              rd_low,
    input  logic              byte_hi,
    input  logic [DATA_W-1:0] result,
    output logic              oe_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int HALF = DATA_W / 2;

    typedef struct packed {
        logic              oe;
        logic [DATA_W-1:0] data;
    } bus_regs_t;

    bus_regs_t cur_q, nxt_d;
    logic [DATA_W-1:0] folded;

    always_comb begin
        folded     = byte_hi ? {result[HALF-1:0], {HALF{1'b1}}} : result;
        nxt_d.oe   = sel_low & rd_low;
        nxt_d.data = nxt_d.oe ? folded : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.oe   <= 1'b0;
            cur_q.data <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign oe_o   = cur_q.oe;
    assign data_o = cur_q.data;

    AST_OE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        oe_o |-> $past(sel_low && rd_low)); // R9
    AST_FOLD_FILL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_o && $past(byte_hi)) |-> (data_o[HALF-1:0] == {HALF{1'b1}})); // R10
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int CONV_CYCLES = 12,
    parameter int ABORT_MIN   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              cnv_n,
    input  logic              sel_n,
    input  logic              rd_n,
    input  logic              hi_byte,
    input  logic [DATA_W-1:0] core_word,
    output logic              busy,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_oe
);
    localparam logic [N_CTRL-1:0] CTRL_IDLE = N_CTRL'(4'b0111);

    logic              rst_n;
    logic [N_CTRL-1:0] raw_ctrl, lvl_ctrl;
    logic [DATA_W-1:0] result;

    assign raw_ctrl[IDX_CNV]  = cnv_n;
    assign raw_ctrl[IDX_SEL]  = sel_n;
    assign raw_ctrl[IDX_RD]   = rd_n;
    assign raw_ctrl[IDX_BYTE] = hi_byte;

    seq_rst_sync #(.STAGES(SYNC_STAGES)) i_rst (
        .clk(clk), .arst_n(arst_n), .rst_n(rst_n)
    );

    seq_ctrl_sync #(.WIDTH(N_CTRL), .STAGES(SYNC_STAGES), .IDLE(CTRL_IDLE)) i_sync (
        .clk(clk), .rst_n(rst_n), .async_i(raw_ctrl), .level_o(lvl_ctrl)
    );

    seq_fsm #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES), .ABORT_MIN(ABORT_MIN)) i_fsm (
        .clk(clk), .rst_n(rst_n),
        .cnv_lvl(lvl_ctrl[IDX_CNV]), .sel_lvl(lvl_ctrl[IDX_SEL]),
        .core_word(core_word), .busy_o(busy), .result_o(result)
    );

    seq_bus #(.DATA_W(DATA_W)) i_bus (
        .clk(clk), .rst_n(rst_n),
        .sel_low(~lvl_ctrl[IDX_SEL]), .rd_low(~lvl_ctrl[IDX_RD]),
        .byte_hi(lvl_ctrl[IDX_BYTE]), .result(result),
        .oe_o(bus_oe), .data_o(bus_data)
    );
endmodule

// File: tb/test_sar_seq_ctrl.sv
module test_sar_seq_ctrl;
    localparam int C  = 12;
    localparam int AM = 3;

    logic        clk = 1'b0;
    logic        arst_n = 1'b0;
    logic        cnv_n = 1'b1, sel_n = 1'b0, rd_n = 1'b1, hi_byte = 1'b0;
    logic [15:0] core_word = 16'h0000;
    logic        busy, bus_oe;
    logic [15:0] bus_data;

    int checks = 0, fails = 0;
    int len;
    logic [15:0] got, model, w;
    logic        oe, b, seen;

    sar_seq_ctrl #(.DATA_W(16), .CONV_CYCLES(C), .ABORT_MIN(AM)) i_sar_seq_ctrl (
        .clk(clk), .arst_n(arst_n), .cnv_n(cnv_n), .sel_n(sel_n), .rd_n(rd_n),
        .hi_byte(hi_byte), .core_word(core_word),
        .busy(busy), .bus_data(bus_data), .bus_oe(bus_oe)
    );

    always #4 clk = ~clk;

    function automatic logic [15:0] fold(input logic [15:0] x, input logic hb);
        return hb ? {x[7:0], 8'hFF} : x;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic measure(output int n);
        int guard = 0;
        n = 0;
        while (!busy && guard < 40) begin @(negedge clk); guard++; end
        while (busy && n < 200) begin n++; @(negedge clk); end
    endtask

    task automatic pulse_cnv();
        @(negedge clk) cnv_n = 1'b0;
        @(negedge clk) cnv_n = 1'b1;
    endtask

    task automatic full_conv(output int n);
        fork
            pulse_cnv();
            measure(n);
        join
        repeat (2) @(negedge clk);
    endtask

    task automatic read_bus(input logic hb, output logic [15:0] d, output logic o);
        rd_n = 1'b0; hi_byte = hb;
        repeat (5) @(negedge clk);
        d = bus_data; o = bus_oe;
        rd_n = 1'b1; hi_byte = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_busy();
        int guard = 0;
        while (!busy && guard < 40) begin @(negedge clk); guard++; end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        arst_n = 1'b1;
        repeat (6) @(negedge clk);

        // R8: reset state
        check("R8 busy after reset", busy, 1'b0);
        read_bus(1'b0, got, oe);
        check("R8 result after reset", got, 16'h0000);
        check("R9 oe with sel and rd low", oe, 1'b1);

        // R1, R3: plain conversion
        core_word = 16'h1234;
        full_conv(len);
        check("R1 busy length", len, C);
        read_bus(1'b0, got, oe);
        check("R3 captured word", got, 16'h1234);
        model = 16'h1234;

        // R10: folded half-word
        read_bus(1'b1, got, oe);
        check("R10 folded read", got, 16'h34FF);

        // R9: bus idle combinations
        sel_n = 1'b1; rd_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R9 oe with sel high", bus_oe, 1'b0);
        check("R9 data zero when idle", bus_data, 16'h0000);
        sel_n = 1'b0; rd_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R9 oe with rd high", bus_oe, 1'b0);
        check("R9 data zero rd high", bus_data, 16'h0000);

        // R2: start ignored with select high
        sel_n = 1'b1;
        repeat (4) @(negedge clk);
        seen = 1'b0;
        pulse_cnv();
        for (int i = 0; i < 12; i++) begin @(negedge clk); if (busy) seen = 1'b1; end
        check("R2 no start with sel high", seen, 1'b0);
        sel_n = 1'b0;
        repeat (5) @(negedge clk);
        read_bus(1'b0, got, oe);
        check("R2 result untouched", got, model);

        // R11: previous result shown while converting
        core_word = 16'hBEEF;
        rd_n = 1'b0;
        repeat (4) @(negedge clk);
        fork
            pulse_cnv();
            begin wait_busy(); repeat (2) @(negedge clk);
                  check("R11 old result during busy", bus_data, model); end
        join
        repeat (C + 4) @(negedge clk);
        check("R3 new result after busy", bus_data, 16'hBEEF);
        rd_n = 1'b1;
        model = 16'hBEEF;
        repeat (4) @(negedge clk);

        // R6: early second edge ignored
        core_word = 16'h0F0F;
        fork
            begin
                @(negedge clk) cnv_n = 1'b0;
                @(negedge clk) cnv_n = 1'b1;
                @(negedge clk) cnv_n = 1'b0;
                @(negedge clk) cnv_n = 1'b1;
            end
            measure(len);
        join
        repeat (2) @(negedge clk);
        check("R6 full length despite early edge", len, C);
        read_bus(1'b0, got, oe);
        check("R6 word captured", got, 16'h0F0F);

        // R4: abort by convert edge
        core_word = 16'h7777;
        fork
            begin
                pulse_cnv();
                wait_busy();
                repeat (2) @(negedge clk);
                cnv_n = 1'b0;
                @(negedge clk) cnv_n = 1'b1;
            end
            measure(len);
        join
        repeat (2) @(negedge clk);
        check("R4 busy cut short", len < C, 1'b1);
        read_bus(1'b0, got, oe);
        check("R4 result cleared", got, 16'h0000);

        // R5: abort by select edge
        core_word = 16'h5555;
        full_conv(len);
        core_word = 16'h6666;
        fork
            begin
                pulse_cnv();
                wait_busy();
                @(negedge clk) sel_n = 1'b1;
                repeat (2) @(negedge clk);
                sel_n = 1'b0;
            end
            measure(len);
        join
        repeat (2) @(negedge clk);
        check("R5 busy cut short", len < C, 1'b1);
        read_bus(1'b0, got, oe);
        check("R5 result cleared", got, 16'h0000);

        // R7: abort edge lands on the final conversion cycle
        core_word = 16'h2222;
        full_conv(len);
        core_word = 16'h4321;
        fork
            begin
                @(negedge clk) cnv_n = 1'b0;
                @(negedge clk) cnv_n = 1'b1;
                repeat (C - 1) @(negedge clk);
                cnv_n = 1'b0;
                @(negedge clk) cnv_n = 1'b1;
            end
            measure(len);
        join
        repeat (4) @(negedge clk);
        check("R7 busy full length", len, C);
        check("R7 no restart", busy, 1'b0);
        read_bus(1'b0, got, oe);
        check("R7 abort wins", got, 16'h0000);

        // R12: extreme codes
        core_word = 16'h7FFF; full_conv(len); read_bus(1'b0, got, oe);
        check("R12 code 7FFF", got, 16'h7FFF);
        core_word = 16'h8000; full_conv(len); read_bus(1'b0, got, oe);
        check("R12 code 8000", got, 16'h8000);
        core_word = 16'hFFFF; full_conv(len); read_bus(1'b1, got, oe);
        check("R12 code FFFF folded", got, 16'hFFFF);

        // R1, R3, R10: random words and read modes
        for (int i = 0; i < 24; i++) begin
            w = 16'($urandom);
            b = 1'($urandom);
            core_word = w;
            full_conv(len);
            check("R1 random busy length", len, C);
            read_bus(b, got, oe);
            check("R10 random read", got, fold(w, b));
            model = w;
        end

        // R8: reset mid-conversion
        core_word = 16'hA5A5;
        fork
            pulse_cnv();
            wait_busy();
        join
        @(negedge clk) arst_n = 1'b0;
        @(negedge clk);
        check("R8 busy drops on reset", busy, 1'b0);
        repeat (2) @(negedge clk);
        arst_n = 1'b1;
        repeat (6) @(negedge clk);
        read_bus(1'b0, got, oe);
        check("R8 result cleared by reset", got, 16'h0000);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule